// File: doc/BRIEF.md
# Coupled DC-Link Pair With PI Transfer Controller

This block is a real-time, fixed-point model of two DC-link capacitors tied together by an ideal bidirectional isolated converter. The converter is treated as instantaneous, so the output of a PI controller is used directly as the current it transfers. That current discharges the grid-side link and charges the output-side link by the same amount. Each link also carries an external inverter load current, which the surrounding model supplies as an input.

The controlled quantity is the difference between the two link voltages, measured against a reference difference. A single multiplier is shared across the proportional term, the integral increment and the two capacitor updates. One model step runs after each start request, which is typically issued once per 10 us calculation period. A one-cycle done pulse marks the moment both link voltages and the transfer current are valid.

All quantities are 18-bit two's complement. Products are rescaled by an arithmetic right shift of 15, which rounds toward minus infinity. Every stored result saturates at the 18-bit limits (+131071 and -131072).

Top module: `dclink_pair_model`

## Requirements
- R1: After reset, v_grid equals INIT_GRID (default 8000), v_out equals INIT_OUT (default 6000), pi_out is 0, done is 0 and the integrator state is 0.
- R2: A start that is high on a clock edge while the block is idle begins one step. done is high for exactly one cycle, 6 clock cycles after that edge.
- R3: A start raised while a step is in progress is ignored. No extra step runs and no second done pulse appears.
- R4: Between steps, v_grid, v_out and pi_out hold their values whatever the other inputs do.
- R5: Each step forms err = sat(v_grid - v_out - ref_diff) from the link voltages held before the step.
- R6: The step computes P = sat((err*KP)>>>15) and inc = sat((err*KI)>>>15), with defaults KP=1800 and KI=400. It then sets I = sat(I + inc) and pi_out = sat(P + I).
- R7: Anti-windup: the integrator keeps its old value when the previous pi_out is +131071 and inc > 0, or when the previous pi_out is -131072 and inc < 0.
- R8: After the new pi_out is formed, the grid-side link updates as v_grid = sat(v_grid + (((-pi_out - load_grid)*gain_grid)>>>15)), with the intermediate terms kept at full width.
- R9: After v_grid, the output-side link updates as v_out = sat(v_out + (((pi_out - load_out)*gain_out)>>>15)). v_out never changes on the same edge as v_grid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one model step |
| ref_diff | input | 18 | Reference for grid minus output link voltage |
| load_grid | input | 18 | Grid inverter load current on the grid-side link |
| load_out | input | 18 | Output inverter load current on the output-side link |
| gain_grid | input | 18 | Integration gain of the grid-side capacitor |
| gain_out | input | 18 | Integration gain of the output-side capacitor |
| v_grid | output | 18 | Grid-side link voltage state |
| v_out | output | 18 | Output-side link voltage state |
| pi_out | output | 18 | Transfer current from the PI controller |
| done | output | 1 | One-cycle pulse when a step has finished |

## Verification
A wrong error or integrator value cannot be seen directly. It shows up in pi_out at the done pulse of the same step, and it skews both link voltages in the same cycle. It keeps doing so on every later step, because the integrator and the links are feedback states. The long windup run with the links frozen isolates the integrator: a missing clamp or missing hold shows up as a pi_out that drifts or recovers too slowly once the reference reverses. Errors in sign or ordering between the two links show up as mismatched link voltages at the first done pulse after the fault.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    // step sequence; one state per cycle, shared multiplier used in four of them
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ERR,
        ST_PMUL,
        ST_IMUL,
        ST_PI,
        ST_LGRID,
        ST_LOUT
    } step_e;

    // cycles from the accepting edge to done becoming visible
    localparam int STEP_CYCLES = 6;
endpackage

// File: rtl/dcl_mul.sv
module dcl_mul #(
    parameter int AW    = 20,
    parameter int BW    = 18,
    parameter int SHIFT = 15,
    localparam int PW   = AW + BW
) (
    input  logic signed [AW-1:0] a,
    input  logic signed [BW-1:0] b,
    output logic signed [PW-1:0] q
);
    logic signed [PW-1:0] prod;

    always_comb begin
        prod = PW'(a) * PW'(b);
        q    = prod >>> SHIFT;
    end
endmodule

// File: rtl/dcl_seq.sv
module dcl_seq
    import dcl_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    output step_e state,
    output logic  busy,
    output logic  done
);
    typedef struct packed {
        step_e st;
        logic  dn;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.dn = 1'b0;
        unique case (s_q.st)
            ST_IDLE:  if (start) s_d.st = ST_ERR;
            ST_ERR:   s_d.st = ST_PMUL;
            ST_PMUL:  s_d.st = ST_IMUL;
            ST_IMUL:  s_d.st = ST_PI;
            ST_PI:    s_d.st = ST_LGRID;
            ST_LGRID: s_d.st = ST_LOUT;
            ST_LOUT: begin
                s_d.st = ST_IDLE;
                s_d.dn = 1'b1;
            end
            default:  s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, dn: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign state = s_q.st;
    assign busy  = (s_q.st != ST_IDLE);
    assign done  = s_q.dn;
endmodule

// File: rtl/dclink_pair_model.sv
module dclink_pair_model
    import dcl_pkg::*;
#(
    parameter int W         = 18,
    parameter int SHIFT     = 15,
    parameter int KP        = 1800,
    parameter int KI        = 400,
    parameter int INIT_GRID = 8000,
    parameter int INIT_OUT  = 6000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] ref_diff,
    input  logic signed [W-1:0] load_grid,
    input  logic signed [W-1:0] load_out,
    input  logic signed [W-1:0] gain_grid,
    input  logic signed [W-1:0] gain_out,
    output logic signed [W-1:0] v_grid,
    output logic signed [W-1:0] v_out,
    output logic signed [W-1:0] pi_out,
    output logic                done
);
    localparam int AW = W + 2;
    localparam int PW = AW + W;
    localparam logic signed [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [PW-1:0] WMAX = PW'(SMAX);
    localparam logic signed [PW-1:0] WMIN = PW'(SMIN);

    typedef struct packed {
        logic signed [W-1:0] vg;
        logic signed [W-1:0] vo;
        logic signed [W-1:0] pi;
        logic signed [W-1:0] integ;
        logic signed [W-1:0] err;
        logic signed [W-1:0] pterm;
        logic signed [W-1:0] iinc;
    } dp_t;

    function automatic logic signed [W-1:0] sat(input logic signed [PW-1:0] x);
        if (x > WMAX)      return SMAX;
        else if (x < WMIN) return SMIN;
        else               return x[W-1:0];
    endfunction

    step_e state;
    logic  busy;

    dcl_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .state (state),
        .busy  (busy),
        .done  (done)
    );

    dp_t r_d, r_q;
    logic signed [AW-1:0] mul_a;
    logic signed [W-1:0]  mul_b;
    logic signed [PW-1:0] mul_q;

    dcl_mul #(.AW(AW), .BW(W), .SHIFT(SHIFT)) u_mul (
        .a (mul_a),
        .b (mul_b),
        .q (mul_q)
    );

    // operand selection for the single shared multiplier
    always_comb begin
        mul_a = '0;
        mul_b = '0;
        unique case (state)
            ST_PMUL: begin
                mul_a = AW'(r_q.err);
                mul_b = W'(KP);
            end
            ST_IMUL: begin
                mul_a = AW'(r_q.err);
                mul_b = W'(KI);
            end
            ST_LGRID: begin
                mul_a = -AW'(r_q.pi) - AW'(load_grid);
                mul_b = gain_grid;
            end
            ST_LOUT: begin
                mul_a = AW'(r_q.pi) - AW'(load_out);
                mul_b = gain_out;
            end
            default: ;
        endcase
    end

    logic                 hold_i;
    logic signed [W-1:0]  integ_nx;

    always_comb begin
        r_d      = r_q;
        hold_i   = ((r_q.pi == SMAX) && (r_q.iinc > 0)) ||
                   ((r_q.pi == SMIN) && (r_q.iinc < 0));
        integ_nx = hold_i ? r_q.integ
                          : sat(PW'(r_q.integ) + PW'(r_q.iinc));
        unique case (state)
            ST_ERR:   r_d.err   = sat(PW'(r_q.vg) - PW'(r_q.vo) - PW'(ref_diff));
            ST_PMUL:  r_d.pterm = sat(mul_q);
            ST_IMUL:  r_d.iinc  = sat(mul_q);
            ST_PI: begin
                r_d.integ = integ_nx;
                r_d.pi    = sat(PW'(r_q.pterm) + PW'(integ_nx));
            end
            ST_LGRID: r_d.vg    = sat(PW'(r_q.vg) + mul_q);
            ST_LOUT:  r_d.vo    = sat(PW'(r_q.vo) + mul_q);
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.vg    <= W'(INIT_GRID);
            r_q.vo    <= W'(INIT_OUT);
        end else begin
            r_q <= r_d;
        end
    end

    assign v_grid = r_q.vg;
    assign v_out  = r_q.vo;
    assign pi_out = r_q.pi;
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk
    import dcl_pkg::*;
#(
    parameter int W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic signed [W-1:0] v_grid,
    input logic signed [W-1:0] v_out,
    input logic signed [W-1:0] pi_out
);
    logic [3:0] lat_q;

    // counts edges from the accepting one while a step runs
    always_ff @(posedge clk) begin
        if (!rst_n)              lat_q <= '0;
        else if (!busy && start) lat_q <= 4'd1;
        else if (busy)           lat_q <= lat_q + 4'd1;
        else                     lat_q <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (lat_q == 4'(STEP_CYCLES + 1))); // R2

    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> ($stable(v_grid) && $stable(v_out) && $stable(pi_out))); // R4

    AST_LINK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(v_out) |-> $stable(v_grid)); // R9
endmodule

bind dclink_pair_model dcl_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .v_grid (v_grid),
    .v_out  (v_out),
    .pi_out (pi_out)
);

// File: tb/test_dclink_pair_model.sv
module test_dclink_pair_model;
    localparam int W = 18;
    localparam longint SMAX = 131071;
    localparam longint SMIN = -131072;
    localparam longint KP = 1800;
    localparam longint KI = 400;

    // ref_diff, load_grid, load_out, gain_grid, gain_out
    localparam int NV = 6;
    localparam int VEC [0:NV-1][0:4] = '{
        '{0,      0,     0,  4096,  4096},
        '{500,  100,  -200,  8192,  8192},
        '{-1000,  0,     0, 16384,  2048},
        '{0,   3000, -3000, 32767, 32767},
        '{2000, -500,  500,  1000, 30000},
        '{-300,   0,     0,     0,     0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic signed [W-1:0] ref_diff = '0, load_grid = '0, load_out = '0;
    logic signed [W-1:0] gain_grid = '0, gain_out = '0;
    logic signed [W-1:0] v_grid, v_out, pi_out;
    logic done;

    int errors = 0;
    int checks = 0;
    longint m_vg, m_vo, m_pi, m_int, m_inc;

    always #2.5 clk = ~clk;

    dclink_pair_model i_dclink_pair_model (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ref_diff(ref_diff), .load_grid(load_grid), .load_out(load_out),
        .gain_grid(gain_grid), .gain_out(gain_out),
        .v_grid(v_grid), .v_out(v_out), .pi_out(pi_out), .done(done)
    );

    function automatic longint sat(input longint x);
        if (x > SMAX) return SMAX;
        if (x < SMIN) return SMIN;
        return x;
    endfunction

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_step(input longint r, input longint lg, input longint lo,
                              input longint gg, input longint go);
        longint err, p;
        err = sat(m_vg - m_vo - r);
        p = sat((err * KP) >>> 15);
        m_inc = sat((err * KI) >>> 15);
        if (!((m_pi == SMAX && m_inc > 0) || (m_pi == SMIN && m_inc < 0)))
            m_int = sat(m_int + m_inc);
        m_pi = sat(p + m_int);
        m_vg = sat(m_vg + (((-m_pi - lg) * gg) >>> 15));
        m_vo = sat(m_vo + (((m_pi - lo) * go) >>> 15));
    endtask

    task automatic do_step(input int r, input int lg, input int lo,
                           input int gg, input int go, input string tag);
        int n;
        @(negedge clk);
        ref_diff = W'(r); load_grid = W'(lg); load_out = W'(lo);
        gain_grid = W'(gg); gain_out = W'(go);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 20) begin
            @(negedge clk);
            n++;
        end
        model_step(r, lg, lo, gg, go);
        check({tag, " R2 latency"}, n - 1, 6);
        check({tag, " R5/R6 pi_out"}, pi_out, m_pi);
        check({tag, " R8 v_grid"}, v_grid, m_vg);
        check({tag, " R9 v_out"}, v_out, m_vo);
        @(negedge clk);
        check({tag, " R2 done one cycle"}, done, 0);
    endtask

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=finish");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        m_vg = 8000; m_vo = 6000; m_pi = 0; m_int = 0; m_inc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 v_grid", v_grid, 8000);
        check("R1 v_out", v_out, 6000);
        check("R1 pi_out", pi_out, 0);
        check("R1 done", done, 0);

        // R4: idle input activity leaves outputs untouched
        ref_diff = 18'sd9000; load_grid = 18'sd5000; gain_grid = 18'sd30000;
        repeat (5) @(negedge clk);
        check("R4 v_grid idle", v_grid, m_vg);
        check("R4 v_out idle", v_out, m_vo);
        check("R4 pi_out idle", pi_out, m_pi);

        // table-driven steps
        for (int i = 0; i < NV; i++)
            do_step(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4], "vec");

        // R3: start pulsed again mid-step is ignored
        @(negedge clk);
        ref_diff = 18'sd100; load_grid = '0; load_out = '0;
        gain_grid = 18'sd4096; gain_out = 18'sd4096;
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        begin
            int dn = 0;
            for (int k = 0; k < 16; k++) begin
                @(negedge clk);
                if (done) dn++;
            end
            model_step(100, 0, 0, 4096, 4096);
            check("R3 single done", dn, 1);
            check("R3 v_grid one step", v_grid, m_vg);
            check("R3 v_out one step", v_out, m_vo);
        end

        // R7: drive integrator into windup with links frozen
        for (int k = 0; k < 100; k++)
            do_step(-131072, 0, 0, 0, 0, "R7 windup");
        check("R7 pi_out at max", pi_out, SMAX);
        for (int k = 0; k < 4; k++)
            do_step(131071, 0, 0, 0, 0, "R7 recover");

        // R8/R9 saturation of the link states
        do_step(0, 131071, -131072, 131071, 131071, "R8/R9 sat");
        check("R8 v_grid saturated low", v_grid, SMIN);
        check("R9 v_out saturated high", v_out, SMAX);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule